// File: doc/BRIEF.md
# Burst Beat Address Generator

This block produces the low address bits for a short wrapping burst of a synchronous memory. When a burst opens, the external start address is captured. The upper bits of that address are then held for the whole burst. The low bits step through a fixed beat sequence each time the advance input is active. An order strap chooses between two beat orders. In the linear order, the start beat is incremented with wrap-around. In the interleaved order, the start beat is XORed with a beat count. The default build has a two-bit beat field, which gives four beats.

The beat field width is a parameter, and so is the full address width. A third parameter decides how the order strap is used: it can be captured when each burst opens, or it can be used live. Two address-status strobes both open a burst. Their qualification by chip selection, and all write and data handling, belong to neighbouring logic.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and right after it is released, `beat_lsb` and `burst_addr` are all zeros.
- R2: When `strobe_a` is high at a rising edge, `burst_addr` shows the value of `addr_in` from that edge, starting at the edge itself.
- R3: `strobe_b` opens a burst exactly as `strobe_a` does.
- R4: With `order_sel` = 0 (linear order), each advance adds one to the beat field modulo 4. Start 01 gives 01, 10, 11, 00. Start 11 gives 11, 00, 01, 10.
- R5: With `order_sel` = 1 (interleaved order), the k-th beat is the start beat XOR k. The starts 00, 01, 10, 11 give 00 01 10 11, 01 00 11 10, 10 11 00 01, and 11 10 01 00.
- R6: With `step_n` high and no strobe, both outputs hold their value from edge to edge.
- R7: A strobe takes priority over an advance in the same cycle. The new start address is loaded and the old burst does not step.
- R8: During a burst, the bits of `burst_addr` above the beat field keep their loaded value, whatever `addr_in` does.
- R9: After the fourth beat, the next advance returns to the start beat of the same sequence. The upper bits do not change.
- R10: A strobe in the middle of a burst restarts the sequence at the new start address, in the order the strap selects at that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_a | input | 1 | First address-status strobe; high opens a burst |
| strobe_b | input | 1 | Second address-status strobe; high opens a burst |
| step_n | input | 1 | Active-low advance; high suspends the burst |
| order_sel | input | 1 | Beat order strap: 0 = linear, 1 = interleaved (tie high when unused) |
| addr_in | input | AW | External start address |
| beat_lsb | output | BEAT_W | Current beat field |
| burst_addr | output | AW | Held upper bits joined with the beat field |

## Verification
All state sits in registers, and both outputs are decoded straight from them. So every effect of a strobe or an advance shows up on the outputs one rising edge after the cycle in which it was driven. The bench changes inputs only on the falling edge. After each rising edge it waits for the next falling edge and compares the outputs there, so each result is read one edge after its stimulus. Expected beats come from the start value and the beat number: an addition modulo 4 for the linear order, an XOR for the interleaved order. Suspend and ignored-input cases are read on the outputs before the next stimulus is applied.

// File: rtl/burst_pkg.sv
package burst_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } order_e;

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
   parameter int AW     = 19,
   parameter int BEAT_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [AW-1:0]        addr_in,
   output logic [AW-BEAT_W-1:0] base_hi,
   output logic [BEAT_W-1:0]    base_lo
);
   localparam int HI_W = AW - BEAT_W;

   generate
      if (HI_W < 1) begin : g_bad_width
         $error("burst_base_reg: AW must exceed BEAT_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_hi <= '0;
         base_lo <= '0;
      end else if (load) begin
         base_hi <= addr_in[AW-1:BEAT_W];
         base_lo <= addr_in[BEAT_W-1:0];
      end
   end

   // R8: without a load the captured upper bits never move
   p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(base_hi));

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   output logic [BEAT_W-1:0] cnt
);
   localparam logic [BEAT_W-1:0] LAST = {BEAT_W{1'b1}};

   generate
      if (BEAT_W < 1) begin : g_bad_beat
         $error("burst_beat_ctr: BEAT_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= '0;
      end else if (advance) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R9: the step after the last beat returns to beat zero
   p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && cnt == LAST) |=> cnt == '0);

   // R7: a load always restarts the beat count
   p_load_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt == '0);

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_pkg::*;
#(
   parameter int BEAT_W     = 2,
   parameter bit MODE_LATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic              order_in,
   input  logic [BEAT_W-1:0] base_lo,
   input  logic [BEAT_W-1:0] cnt,
   output logic [BEAT_W-1:0] lsb
);
   order_e mode_eff;

   generate
      if (MODE_LATCH) begin : g_latched
         order_e mode_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    mode_q <= ORD_LINEAR;
            else if (load) mode_q <= order_e'(order_in);
         end
         assign mode_eff = mode_q;
      end else begin : g_live
         assign mode_eff = order_e'(order_in);
      end
   endgenerate

   always_comb begin
      unique case (mode_eff)
         ORD_LINEAR:     lsb = base_lo + cnt;
         ORD_INTERLEAVE: lsb = base_lo ^ cnt;
         default:        lsb = base_lo;
      endcase
   end

   // R4: in linear order every advance adds one to the beat field
   p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && mode_eff == ORD_LINEAR) |=>
         lsb == BEAT_W'($past(lsb) + 1'b1));

   // R5: in interleaved order the beat changes by the bits the count flips
   p_interleave_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && mode_eff == ORD_INTERLEAVE) |=>
         (lsb ^ $past(lsb)) == ($past(cnt) ^ BEAT_W'($past(cnt) + 1'b1)));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int AW         = 19,
   parameter int BEAT_W     = 2,
   parameter bit MODE_LATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_a,
   input  logic              strobe_b,
   input  logic              step_n,
   input  logic              order_sel,
   input  logic [AW-1:0]     addr_in,
   output logic [BEAT_W-1:0] beat_lsb,
   output logic [AW-1:0]     burst_addr
);
   localparam int HI_W = AW - BEAT_W;

   logic              load;
   logic              advance;
   logic [HI_W-1:0]   base_hi;
   logic [BEAT_W-1:0] base_lo;
   logic [BEAT_W-1:0] cnt;

   assign load    = strobe_a | strobe_b;
   assign advance = ~step_n & ~load;

   burst_base_reg #(.AW(AW), .BEAT_W(BEAT_W)) i_base (
      .clk(clk), .rst_n(rst_n), .load(load), .addr_in(addr_in),
      .base_hi(base_hi), .base_lo(base_lo)
   );

   burst_beat_ctr #(.BEAT_W(BEAT_W)) i_ctr (
      .clk(clk), .rst_n(rst_n), .load(load), .advance(advance), .cnt(cnt)
   );

   burst_order_map #(.BEAT_W(BEAT_W), .MODE_LATCH(MODE_LATCH)) i_map (
      .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
      .order_in(order_sel), .base_lo(base_lo), .cnt(cnt), .lsb(beat_lsb)
   );

   assign burst_addr = {base_hi, beat_lsb};

   // R1: the first edge after reset shows an all-zero address
   p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> burst_addr == '0);

   // R2: a strobe places the external address on the output
   p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> burst_addr == $past(addr_in));

   // R6: a suspended burst keeps its address
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && step_n) |=> $stable(burst_addr));

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
   localparam int AW     = 19;
   localparam int BEAT_W = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              strobe_a = 1'b0;
   logic              strobe_b = 1'b0;
   logic              step_n = 1'b1;
   logic              order_sel = 1'b1;
   logic [AW-1:0]     addr_in = '0;
   logic [BEAT_W-1:0] beat_lsb;
   logic [AW-1:0]     burst_addr;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   burst_addr_gen #(.AW(AW), .BEAT_W(BEAT_W)) i_burst_addr_gen (
      .clk(clk), .rst_n(rst_n), .strobe_a(strobe_a), .strobe_b(strobe_b),
      .step_n(step_n), .order_sel(order_sel), .addr_in(addr_in),
      .beat_lsb(beat_lsb), .burst_addr(burst_addr)
   );

   function automatic logic [BEAT_W-1:0] exp_beat(input logic [BEAT_W-1:0] s,
                                                  input int k, input logic inter);
      logic [BEAT_W-1:0] kk = BEAT_W'(k);
      return inter ? (s ^ kk) : BEAT_W'(s + kk);
   endfunction

   task automatic chk(input string rq, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic edge_step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic open_burst(input logic use_b, input logic inter, input logic [AW-1:0] a);
      order_sel = inter;
      addr_in   = a;
      strobe_a  = !use_b;
      strobe_b  = use_b;
      step_n    = 1'b1;
      edge_step();
      strobe_a  = 1'b0;
      strobe_b  = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) edge_step();
      chk("R1 in reset", burst_addr, '0);
      rst_n = 1'b1;
      edge_step();
      chk("R1 after release", {{(AW-BEAT_W){1'b0}}, beat_lsb}, '0);
      chk("R1 after release addr", burst_addr, '0);
   endtask

   task automatic t_linear(input logic [BEAT_W-1:0] s);
      logic [AW-1:0] a = {17'h0B3C5, s};
      open_burst(1'b0, 1'b0, a);
      chk("R2 linear load", burst_addr, a);
      step_n = 1'b0;
      for (int k = 1; k <= 4; k++) begin
         addr_in = ~addr_in;
         edge_step();
         chk(k == 4 ? "R9 linear wrap" : "R4 linear beat", burst_addr,
             {a[AW-1:BEAT_W], exp_beat(s, k, 1'b0)});
      end
      step_n = 1'b1;
   endtask

   task automatic t_interleave(input logic [BEAT_W-1:0] s);
      logic [AW-1:0] a = {17'h12A4E, s};
      open_burst(1'b0, 1'b1, a);
      chk("R2 interleave load", burst_addr, a);
      step_n = 1'b0;
      for (int k = 1; k <= 4; k++) begin
         edge_step();
         chk(k == 4 ? "R9 interleave wrap" : "R5 interleave beat", burst_addr,
             {a[AW-1:BEAT_W], exp_beat(s, k, 1'b1)});
      end
      step_n = 1'b1;
   endtask

   task automatic t_hold();
      logic [AW-1:0] a = {17'h05555, 2'b10};
      open_burst(1'b0, 1'b0, a);
      step_n = 1'b0;
      edge_step();
      step_n = 1'b1;
      addr_in = '1;
      repeat (3) begin
         edge_step();
         chk("R6 suspend holds", burst_addr, {a[AW-1:BEAT_W], 2'b11});
      end
      step_n = 1'b0;
      edge_step();
      chk("R6 resume after suspend", burst_addr, {a[AW-1:BEAT_W], 2'b00});
      step_n = 1'b1;
   endtask

   task automatic t_strobe_b();
      logic [AW-1:0] a = {17'h1FFFE, 2'b11};
      open_burst(1'b1, 1'b1, a);
      chk("R3 second strobe loads", burst_addr, a);
      step_n = 1'b0;
      edge_step();
      chk("R3 second strobe burst", burst_addr, {a[AW-1:BEAT_W], 2'b10});
      step_n = 1'b1;
   endtask

   task automatic t_priority();
      logic [AW-1:0] a = {17'h00F0F, 2'b01};
      logic [AW-1:0] b = {17'h13579, 2'b10};
      open_burst(1'b0, 1'b0, a);
      step_n = 1'b0;
      edge_step();
      addr_in  = b;
      strobe_a = 1'b1;
      edge_step();
      strobe_a = 1'b0;
      chk("R7 strobe beats advance", burst_addr, b);
      step_n = 1'b1;
   endtask

   task automatic t_ignore_addr();
      logic [AW-1:0] a = {17'h0AAAA, 2'b00};
      open_burst(1'b0, 1'b1, a);
      step_n = 1'b0;
      addr_in = {17'h15555, 2'b11};
      edge_step();
      chk("R8 upper bits fixed", burst_addr, {a[AW-1:BEAT_W], 2'b01});
      addr_in = '0;
      edge_step();
      chk("R8 upper bits fixed again", burst_addr, {a[AW-1:BEAT_W], 2'b10});
      step_n = 1'b1;
   endtask

   task automatic t_reload();
      logic [AW-1:0] a = {17'h01234, 2'b00};
      logic [AW-1:0] b = {17'h04321, 2'b01};
      open_burst(1'b0, 1'b0, a);
      step_n = 1'b0;
      repeat (2) edge_step();
      step_n = 1'b1;
      open_burst(1'b1, 1'b1, b);
      chk("R10 restart load", burst_addr, b);
      step_n = 1'b0;
      edge_step();
      chk("R10 restart beat 1", burst_addr, {b[AW-1:BEAT_W], 2'b00});
      edge_step();
      chk("R10 restart beat 2", burst_addr, {b[AW-1:BEAT_W], 2'b11});
      step_n = 1'b1;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_linear(2'b01);
      t_linear(2'b11);
      t_linear(2'b00);
      for (int s = 0; s < 4; s++) t_interleave(BEAT_W'(s));
      t_hold();
      t_strobe_b();
      t_priority();
      t_ignore_addr();
      t_reload();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule